// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the target side of a three-wire serial nonvolatile memory organised in 16-bit words. A host selects it with a chip-select line, clocks framed commands in on a data input, and reads words or a ready/busy flag back on a data output that has its own output enable. A program-enable input gates every command that changes the contents. The serial lines are oversampled by a fast system clock, so all internal state runs in that single clock domain. The memory cells are a register array that can map to block RAM. Its depth is a parameter and smaller than the address field in the frame, so the upper address bits are dropped.

A frame is a 1 start bit, two opcode bits and a ten-bit address. Write-type frames that carry data add sixteen data bits. Each frame is either a single-word read, write or erase, or one of four extended commands: enable, disable, erase-all and write-all. A read streams words until chip-select falls. A write-type command is accepted when its frame ends, but it only runs when chip-select falls. It then runs for a fixed number of system clocks. While it runs, the target can be selected to watch its status on the data output.

Top module: `ee3w_target`

## Requirements
- R1: After reset the data output is disabled (sdout_oe_o = 0) and write-type commands are refused until an enable command arrives; reset does not alter stored words.
- R2: Zeros before the start bit are skipped. The first 1 is the start bit. Then come opcode bits [1:0] and address bits [9:0], MSB first, then, for write and write-all, data bits [15:0], MSB first. All bits are sampled on the rising serial clock.
- R3: Opcode 2'b10 is a read. After the rising clock that carries the last address bit, the output is enabled and shows one 0 bit. Each later rising clock presents the next bit of the addressed word, MSB first.
- R4: While selected, a read goes on with the following address and no extra 0 bit. After the last word of the array it wraps to word 0.
- R5: Opcode 2'b01 (write) replaces the addressed word with the 16 data bits. The word needs no erase first, and the store takes place only after chip-select falls.
- R6: Opcode 2'b11 (erase) sets the addressed word to 16'hFFFF.
- R7: Opcode 2'b00 with address bits [9:8] = 2'b10 erases every word to 16'hFFFF. With [9:8] = 2'b01 it writes the 16 data bits into every word.
- R8: Write, erase, erase-all and write-all take effect only if the program-enable input is high when chip-select falls. Enable ([9:8] = 2'b11) and disable ([9:8] = 2'b00) act whatever the program-enable level.
- R9: After a disable command, write-type commands have no effect until the next enable command.
- R10: Once programming has started, selecting the target enables the data output. The output is 0 while programming runs and 1 after it has finished.
- R11: A 1 clocked in while status is shown is not a start bit. The output is disabled at the next falling serial clock, and a later start bit begins a command.
- R12: Commands clocked in during programming are ignored. A frame cut short by chip-select falling is discarded.
- R13: While chip-select is low the data output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdin_i | input | 1 | Serial data from the host |
| prog_en_i | input | 1 | Program enable for content-changing commands |
| sdout_o | output | 1 | Serial data / status bit to the host |
| sdout_oe_o | output | 1 | Output enable for sdout_o (0 = high impedance) |

## Verification
One rising serial clock can carry two meanings. With status shown and programming finished, the same 1 on the data input could release the output or open a new frame. The bench forces this case by clocking one 1 while status is visible and keeping chip-select high, then sending a complete read frame at once. It checks that the output enable stays high until the falling clock, drops afterwards, and that the read frame that follows yields the dummy bit and the right word. A misparse by one bit would corrupt both. The second collision is the end of one sequential word with the fetch of the next at the wrap point. It is judged by reading across the last word into word 0.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_ERASE = 3'd3,
    CMD_ERAL  = 3'd4,
    CMD_WRAL  = 3'd5,
    CMD_EWEN  = 3'd6,
    CMD_EWDS  = 3'd7
  } cmd_e;

  // opcode field (two bits after the start bit)
  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  // extended command selector: two top address bits
  localparam logic [1:0] EXT_WDIS  = 2'b00;
  localparam logic [1:0] EXT_WALL  = 2'b01;
  localparam logic [1:0] EXT_EALL  = 2'b10;
  localparam logic [1:0] EXT_WEN   = 2'b11;

endpackage

// File: rtl/ee3w_pinsync.sv
module ee3w_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdin_i,
  input  logic pen_i,
  output logic cs_q,
  output logic di_q,
  output logic pe_q,
  output logic sk_rise,
  output logic sk_fall,
  output logic cs_fall
);
  localparam int NPIN = 4;

  logic [STAGES-1:0][NPIN-1:0] chain;
  logic [NPIN-1:0]             last;
  logic                        sk_q;
  logic                        sk_prev;
  logic                        cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain   <= '0;
      sk_prev <= 1'b0;
      cs_prev <= 1'b0;
    end else begin
      chain[0] <= {sel_i, sclk_i, sdin_i, pen_i};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      sk_prev <= sk_q;
      cs_prev <= cs_q;
    end
  end

  assign last    = chain[STAGES-1];
  assign cs_q    = last[3];
  assign sk_q    = last[2];
  assign di_q    = last[1];
  assign pe_q    = last[0];
  assign sk_rise = sk_q & ~sk_prev;
  assign sk_fall = ~sk_q & sk_prev;
  assign cs_fall = ~cs_q & cs_prev;

endmodule

// File: rtl/ee3w_cmd.sv
module ee3w_cmd
  import ee3w_pkg::*;
#(
  parameter int FAW = 10,
  parameter int DW  = 16,
  parameter int MAW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_q,
  input  logic           cs_fall,
  input  logic           di_q,
  input  logic           pe_q,
  input  logic           sk_rise,
  input  logic           busy,
  input  logic           stat_mode,
  output logic           rd_go,
  output logic [MAW-1:0] rd_addr,
  output logic           prog_go,
  output cmd_e           prog_cmd,
  output logic [MAW-1:0] prog_addr,
  output logic [DW-1:0]  prog_data,
  output logic           wen
);
  localparam int HDR_W = 2 + FAW;
  localparam int MAXW  = (HDR_W > DW) ? HDR_W : DW;
  localparam int CW    = $clog2(MAXW) + 1;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_DONE, S_READ} st_e;

  st_e            st;
  logic [HDR_W-1:0] hdr;
  logic [DW-1:0]  dat;
  logic [CW-1:0]  cnt;
  cmd_e           pend;
  cmd_e           kind;
  logic [MAW-1:0] paddr;

  logic           bit_en;
  logic [HDR_W-1:0] hdr_nx;
  logic [DW-1:0]  dat_nx;
  logic [1:0]     opc;
  logic [1:0]     ext;

  // bits are ignored while programming or while status owns the line
  assign bit_en = sk_rise & cs_q & ~busy & ~stat_mode;
  assign hdr_nx = {hdr[HDR_W-2:0], di_q};
  assign dat_nx = {dat[DW-2:0], di_q};
  assign opc    = hdr_nx[HDR_W-1 -: 2];
  assign ext    = hdr_nx[FAW-1 -: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      hdr       <= '0;
      dat       <= '0;
      cnt       <= '0;
      pend      <= CMD_NONE;
      kind      <= CMD_NONE;
      paddr     <= '0;
      wen       <= 1'b0;
      rd_go     <= 1'b0;
      rd_addr   <= '0;
      prog_go   <= 1'b0;
      prog_cmd  <= CMD_NONE;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      rd_go   <= 1'b0;
      prog_go <= 1'b0;
      if (cs_fall) begin
        st   <= S_IDLE;
        pend <= CMD_NONE;
        if (pend != CMD_NONE && wen && pe_q && !busy) begin
          prog_go   <= 1'b1;
          prog_cmd  <= pend;
          prog_addr <= paddr;
          prog_data <= dat;
        end
      end else if (!cs_q) begin
        st   <= S_IDLE;
        pend <= CMD_NONE;
      end else if (bit_en) begin
        case (st)
          S_IDLE: begin
            if (di_q) begin
              st  <= S_HDR;
              cnt <= '0;
            end
          end
          S_HDR: begin
            hdr <= hdr_nx;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HDR_W - 1)) begin
              paddr <= hdr_nx[MAW-1:0];
              cnt   <= '0;
              case (opc)
                OPC_READ: begin
                  st      <= S_READ;
                  rd_go   <= 1'b1;
                  rd_addr <= hdr_nx[MAW-1:0];
                end
                OPC_WRITE: begin
                  st   <= S_DATA;
                  kind <= CMD_WRITE;
                end
                OPC_ERASE: begin
                  st   <= S_DONE;
                  pend <= CMD_ERASE;
                end
                default: begin
                  case (ext)
                    EXT_WEN:  begin wen <= 1'b1;     st <= S_DONE; end
                    EXT_WDIS: begin wen <= 1'b0;     st <= S_DONE; end
                    EXT_EALL: begin pend <= CMD_ERAL; st <= S_DONE; end
                    default:  begin kind <= CMD_WRAL; st <= S_DATA; end
                  endcase
                end
              endcase
            end
          end
          S_DATA: begin
            dat <= dat_nx;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) begin
              pend <= kind;
              st   <= S_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ee3w_dout.sv
module ee3w_dout #(
  parameter int DW  = 16,
  parameter int MAW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_q,
  input  logic           sk_rise,
  input  logic           sk_fall,
  input  logic           di_q,
  input  logic           rd_go,
  input  logic [MAW-1:0] rd_addr,
  input  logic           prog_go,
  input  logic           busy,
  input  logic [DW-1:0]  mem_q,
  output logic [MAW-1:0] mem_raddr,
  output logic           reading,
  output logic           stat_mode,
  output logic           sdout,
  output logic           sdout_oe
);
  localparam int CNTW = $clog2(DW);

  logic [MAW-1:0]  rd_ptr;
  logic [DW-1:0]   sh;
  logic [CNTW-1:0] bcnt;
  logic            rd_bit;
  logic            rel_pend;

  // read streaming: bcnt == 0 means the next rising clock loads a word
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      sh      <= '0;
      bcnt    <= '0;
      rd_bit  <= 1'b0;
      reading <= 1'b0;
    end else if (!cs_q) begin
      reading <= 1'b0;
    end else if (rd_go) begin
      reading <= 1'b1;
      rd_ptr  <= rd_addr;
      bcnt    <= '0;
      rd_bit  <= 1'b0;
    end else if (reading && sk_rise) begin
      if (bcnt == '0) begin
        rd_bit <= mem_q[DW-1];
        sh     <= {mem_q[DW-2:0], 1'b0};
        bcnt   <= CNTW'(DW - 1);
        rd_ptr <= rd_ptr + 1'b1;
      end else begin
        rd_bit <= sh[DW-1];
        sh     <= {sh[DW-2:0], 1'b0};
        bcnt   <= bcnt - 1'b1;
      end
    end
  end

  // status display and its release by a clocked-in 1
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_mode <= 1'b0;
      rel_pend  <= 1'b0;
    end else if (prog_go) begin
      stat_mode <= 1'b1;
      rel_pend  <= 1'b0;
    end else if (!cs_q) begin
      rel_pend  <= 1'b0;
    end else if (stat_mode && !rel_pend && sk_rise && di_q) begin
      rel_pend  <= 1'b1;
    end else if (rel_pend && sk_fall) begin
      stat_mode <= 1'b0;
      rel_pend  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdout    <= 1'b0;
      sdout_oe <= 1'b0;
    end else begin
      sdout_oe <= cs_q & (reading | stat_mode);
      sdout    <= reading ? rd_bit : ~busy;
    end
  end

  assign mem_raddr = rd_ptr;

endmodule

// File: rtl/ee3w_prog.sv
module ee3w_prog
  import ee3w_pkg::*;
#(
  parameter int DW          = 16,
  parameter int MAW         = 6,
  parameter int PROG_CYCLES = 300
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           prog_go,
  input  cmd_e           prog_cmd,
  input  logic [MAW-1:0] prog_addr,
  input  logic [DW-1:0]  prog_data,
  output logic           busy,
  output logic           mem_we,
  output logic [MAW-1:0] mem_waddr,
  output logic [DW-1:0]  mem_wdata
);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic          sweep;
  logic          all_mode;
  logic [TW-1:0] tmr;
  logic          go_all;
  logic          go_ones;

  assign go_all  = (prog_cmd == CMD_ERAL) || (prog_cmd == CMD_WRAL);
  assign go_ones = (prog_cmd == CMD_ERAL) || (prog_cmd == CMD_ERASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      sweep     <= 1'b0;
      all_mode  <= 1'b0;
      tmr       <= '0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else if (prog_go && !busy) begin
      busy      <= 1'b1;
      sweep     <= 1'b1;
      all_mode  <= go_all;
      mem_waddr <= go_all ? '0 : prog_addr;
      mem_wdata <= go_ones ? '1 : prog_data;
      tmr       <= TW'(PROG_CYCLES - 1);
    end else if (busy) begin
      if (sweep) begin
        if (!all_mode || (&mem_waddr)) sweep <= 1'b0;
        else                           mem_waddr <= mem_waddr + 1'b1;
      end
      if (tmr != '0)  tmr  <= tmr - 1'b1;
      else if (!sweep) busy <= 1'b0;
    end
  end

  assign mem_we = busy & sweep;

endmodule

// File: rtl/ee3w_mem.sv
module ee3w_mem #(
  parameter int DW  = 16,
  parameter int MAW = 6
) (
  input  logic           clk,
  input  logic           we,
  input  logic [MAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [MAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  localparam int DEPTH = 1 << MAW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/ee3w_target.sv
module ee3w_target
  import ee3w_pkg::*;
#(
  parameter int FRAME_AW    = 10,
  parameter int DATA_W      = 16,
  parameter int MEM_AW      = 6,
  parameter int PROG_CYCLES = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdin_i,
  input  logic prog_en_i,
  output logic sdout_o,
  output logic sdout_oe_o
);
  logic              cs_q, di_q, pe_q, sk_rise, sk_fall, cs_fall;
  logic              rd_go, prog_go, wen, busy, mem_we, reading, stat_mode;
  logic [MEM_AW-1:0] rd_addr, prog_addr, mem_waddr, mem_raddr;
  logic [DATA_W-1:0] prog_data, mem_wdata, mem_q;
  cmd_e              prog_cmd;

  ee3w_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sel_i(sel_i), .sclk_i(sclk_i), .sdin_i(sdin_i),
    .pen_i(prog_en_i), .cs_q(cs_q), .di_q(di_q), .pe_q(pe_q),
    .sk_rise(sk_rise), .sk_fall(sk_fall), .cs_fall(cs_fall)
  );

  ee3w_cmd #(.FAW(FRAME_AW), .DW(DATA_W), .MAW(MEM_AW)) u_cmd (
    .clk(clk), .rst(rst), .cs_q(cs_q), .cs_fall(cs_fall), .di_q(di_q),
    .pe_q(pe_q), .sk_rise(sk_rise), .busy(busy), .stat_mode(stat_mode),
    .rd_go(rd_go), .rd_addr(rd_addr), .prog_go(prog_go), .prog_cmd(prog_cmd),
    .prog_addr(prog_addr), .prog_data(prog_data), .wen(wen)
  );

  ee3w_dout #(.DW(DATA_W), .MAW(MEM_AW)) u_dout (
    .clk(clk), .rst(rst), .cs_q(cs_q), .sk_rise(sk_rise), .sk_fall(sk_fall),
    .di_q(di_q), .rd_go(rd_go), .rd_addr(rd_addr), .prog_go(prog_go),
    .busy(busy), .mem_q(mem_q), .mem_raddr(mem_raddr), .reading(reading),
    .stat_mode(stat_mode), .sdout(sdout_o), .sdout_oe(sdout_oe_o)
  );

  ee3w_prog #(.DW(DATA_W), .MAW(MEM_AW), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .prog_go(prog_go), .prog_cmd(prog_cmd),
    .prog_addr(prog_addr), .prog_data(prog_data), .busy(busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  ee3w_mem #(.DW(DATA_W), .MAW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_q)
  );

endmodule

// File: rtl/ee3w_target_chk.sv
module ee3w_target_chk (
  input logic clk,
  input logic rst,
  input logic cs_q,
  input logic pe_q,
  input logic wen,
  input logic busy,
  input logic prog_go,
  input logic mem_we,
  input logic sdout_o,
  input logic sdout_oe_o
);

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (rst)
    !cs_q |=> !sdout_oe_o);  // R13

  AST_BUSY_SHOWS_LOW: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && sdout_oe_o) |-> !sdout_o);  // R10

  AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wen));  // R9

  AST_PROG_NEEDS_PE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(pe_q, 2));  // R8

  AST_STORE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);  // R5

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    prog_go |-> !busy);  // R12

endmodule

bind ee3w_target ee3w_target_chk u_chk (
  .clk(clk), .rst(rst), .cs_q(cs_q), .pe_q(pe_q), .wen(wen), .busy(busy),
  .prog_go(prog_go), .mem_we(mem_we), .sdout_o(sdout_o), .sdout_oe_o(sdout_oe_o)
);

// File: tb/sim_ee3w_target.sv
module sim_ee3w_target;
  localparam int H      = 6;
  localparam int PROGC  = 300;
  localparam int DEPTH  = 64;
  localparam int SETTLE = PROGC + DEPTH + 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0, pen = 1'b1;
  logic sdout, sdout_oe;
  logic smp_d, smp_oe;
  logic [15:0] model [DEPTH];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ee3w_target u0 (
    .clk(clk), .rst(rst), .sel_i(sel), .sclk_i(sclk), .sdin_i(sdin),
    .prog_en_i(pen), .sdout_o(sdout), .sdout_oe_o(sdout_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    @(negedge clk) sdin = b;
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    smp_d = sdout; smp_oe = sdout_oe;
    sclk = 1'b0;
  endtask

  task automatic select_dev();
    @(negedge clk) sel = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic deselect();
    @(negedge clk) begin sclk = 1'b0; sel = 1'b0; end
    repeat (H) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] opc, input logic [9:0] a);
    clk_bit(1'b1);
    for (int i = 1; i >= 0; i--) clk_bit(opc[i]);
    for (int i = 9; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic send_cmd(input logic [1:0] opc, input logic [9:0] a,
                          input bit has_d, input logic [15:0] d);
    select_dev();
    send_hdr(opc, a);
    if (has_d) for (int i = 15; i >= 0; i--) clk_bit(d[i]);
    deselect();
  endtask

  // wait out programming, then release any status display
  task automatic settle();
    repeat (SETTLE) @(negedge clk);
    select_dev();
    clk_bit(1'b1);
    deselect();
  endtask

  task automatic wr_en();  send_cmd(2'b00, 10'b11_0000_0000, 0, 16'h0); endtask
  task automatic wr_dis(); send_cmd(2'b00, 10'b00_0000_0000, 0, 16'h0); endtask

  task automatic read_chk(input string req, input int a, input int nw,
                          input int lead, input bit presel);
    logic [15:0] w;
    if (!presel) select_dev();
    for (int i = 0; i < lead; i++) clk_bit(1'b0);
    send_hdr(2'b10, 10'(a));
    chk({req, " dummy oe"}, {31'd0, smp_oe}, 32'd1);
    chk({req, " dummy bit"}, {31'd0, smp_d}, 32'd0);
    for (int k = 0; k < nw; k++) begin
      w = '0;
      for (int b = 0; b < 16; b++) begin
        clk_bit(1'b0);
        w = {w[14:0], smp_d};
      end
      chk($sformatf("%s word @%0d", req, (a + k) % DEPTH), {16'd0, w},
          {16'd0, model[(a + k) % DEPTH]});
    end
    deselect();
    chk("R13 oe after deselect", {31'd0, sdout_oe}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 oe at reset", {31'd0, sdout_oe}, 32'd0);
    wr_en();
    send_cmd(2'b01, 10'd3, 1, 16'hAAAA); settle(); model[3] = 16'hAAAA;
    @(negedge clk) rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset", {31'd0, sdout_oe}, 32'd0);
    send_cmd(2'b01, 10'd3, 1, 16'h5555); settle();
    wr_en();
    read_chk("R1 refused write and kept word", 3, 1, 0, 0);
  endtask

  task automatic t_bulk();
    send_cmd(2'b00, 10'b01_0000_0000, 1, 16'h3C3C); settle();
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h3C3C;
    read_chk("R7 write-all", 0, DEPTH, 0, 0);
    send_cmd(2'b00, 10'b10_0000_0000, 0, 16'h0); settle();
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    read_chk("R7 erase-all", 20, 3, 0, 0);
  endtask

  task automatic t_write_read();
    send_cmd(2'b01, 10'd5, 1, 16'h1234); settle(); model[5] = 16'h1234;
    send_cmd(2'b01, 10'd6, 1, 16'h8001); settle(); model[6] = 16'h8001;
    send_cmd(2'b01, 10'd63, 1, 16'hFEDC); settle(); model[63] = 16'hFEDC;
    send_cmd(2'b01, 10'd1, 1, 16'h0F0F); settle(); model[1] = 16'h0F0F;
    read_chk("R5 R3 write then read", 6, 1, 0, 0);
    read_chk("R2 leading zeros skipped", 5, 1, 2, 0);
    send_cmd(2'b01, 10'd5, 1, 16'h4321); settle(); model[5] = 16'h4321;
    read_chk("R5 overwrite without erase", 5, 1, 0, 0);
  endtask

  task automatic t_seq();
    read_chk("R4 sequential wrap", 62, 4, 0, 0);
  endtask

  task automatic t_erase();
    send_cmd(2'b11, 10'd6, 0, 16'h0); settle(); model[6] = 16'hFFFF;
    read_chk("R6 erase word", 6, 1, 0, 0);
  endtask

  task automatic t_pe();
    pen = 1'b0;
    send_cmd(2'b01, 10'd7, 1, 16'h0BAD); settle();
    wr_dis();
    pen = 1'b1;
    send_cmd(2'b01, 10'd7, 1, 16'h1111); settle();
    read_chk("R8 pe low blocks, disable acts", 7, 1, 0, 0);
    pen = 1'b0;
    wr_en();
    pen = 1'b1;
    send_cmd(2'b01, 10'd7, 1, 16'h2222); settle(); model[7] = 16'h2222;
    read_chk("R8 enable acts with pe low", 7, 1, 0, 0);
  endtask

  task automatic t_disable();
    wr_dis();
    send_cmd(2'b11, 10'd63, 0, 16'h0); settle();
    send_cmd(2'b00, 10'b01_0000_0000, 1, 16'h0000); settle();
    read_chk("R9 disabled writes", 63, 2, 0, 0);
    wr_en();
  endtask

  task automatic t_status();
    send_cmd(2'b01, 10'd10, 1, 16'hABCD); model[10] = 16'hABCD;
    select_dev();
    chk("R10 busy oe", {31'd0, sdout_oe}, 32'd1);
    chk("R10 busy level", {31'd0, sdout}, 32'd0);
    deselect();
    repeat (SETTLE) @(negedge clk);
    select_dev();
    chk("R10 ready oe", {31'd0, sdout_oe}, 32'd1);
    chk("R10 ready level", {31'd0, sdout}, 32'd1);
    clk_bit(1'b1);
    chk("R11 oe kept until falling clock", {31'd0, smp_oe}, 32'd1);
    repeat (H) @(negedge clk);
    chk("R11 oe off after falling clock", {31'd0, sdout_oe}, 32'd0);
    read_chk("R11 release bit not a start bit", 10, 1, 0, 1);
  endtask

  task automatic t_busy();
    send_cmd(2'b01, 10'd11, 1, 16'h1357); model[11] = 16'h1357;
    select_dev();
    clk_bit(1'b1);
    send_hdr(2'b10, 10'd11);
    chk("R12 read ignored while busy", {31'd0, smp_oe}, 32'd0);
    deselect();
    settle();
    select_dev();
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
    clk_bit(1'b0); clk_bit(1'b0); clk_bit(1'b0);
    deselect();
    repeat (H) @(negedge clk);
    select_dev();
    chk("R12 cut frame starts nothing", {31'd0, sdout_oe}, 32'd0);
    deselect();
    read_chk("R12 word after ignored frames", 11, 1, 0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_bulk();
    t_write_read();
    t_seq();
    t_erase();
    t_pe();
    t_disable();
    t_status();
    t_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule